// File: doc/BRIEF.md
# External Reference Frequency Synchronizer

This block keeps the delay setting of a ring-oscillator pulse-width modulator in step with an external reference clock. The setting is a 4-bit frequency word, and the oscillator's delay cells take it directly. On each rising edge of the reference, the block sends a launch pulse into a replica of the oscillator's delay line. That replica holds half the core stages plus one, so nine stages for a 16-stage core. At the falling edge that follows, the block samples the outputs of the last two replica stages. The two-bit snapshot shows whether half a switching period is longer or shorter than half a reference period. At the next rising edge the block steps the frequency word up by one, steps it down by one, or holds it.

The replica line itself is analog and lies outside this block. Its two tap outputs come back as plain inputs. The scheme assumes the reference has a 50% duty cycle, because the falling edge marks the half period. A select input lets the system supply the frequency word from outside, which bypasses tracking. The block also reports a lock flag and a sticky flag for impossible snapshots.

Top module: `fsync_ctrl`

## Requirements
- R1: While rst_n is low, freq_word_o reads 8 (with ext_sel_i low), locked_o and illegal_o read 0, and launch_o stays low.
- R2: After reset release, launch_o follows the high phase of ref_clk from the first falling edge onward: high while ref_clk is high, low while it is low.
- R3: The snapshot {tap_prev_i, tap_last_i} is captured at each falling edge of ref_clk. It is used at the next rising edge, and only when a launch went out at the rising edge before the capture, so the first adjustment after reset comes at the second rising edge. Snapshot 00 (slow) increments the frequency word by one.
- R4: Snapshot 11 (fast) decrements the frequency word by one.
- R5: Snapshot 10 (matched) and snapshot 01 leave the frequency word unchanged.
- R6: The frequency word saturates at 15 on increment and at 0 on decrement, without wrapping.
- R7: A used snapshot of 01 sets illegal_o, which stays set until reset.
- R8: locked_o rises once 4 consecutive used snapshots are 10. Any other used snapshot clears it and restarts the count.
- R9: While ext_sel_i is high, freq_word_o equals ext_word_i, snapshots are ignored (the internal word and illegal_o are unchanged), and locked_o is cleared. Tracking resumes from the held word when ext_sel_i falls.
- R10: With ext_sel_i low, freq_word_o changes by at most one step per reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | External reference clock, 50% duty cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel_i | input | 1 | Selects the externally supplied frequency word |
| ext_word_i | input | 4 | Externally supplied frequency word |
| tap_prev_i | input | 1 | Output of the second-to-last replica stage |
| tap_last_i | input | 1 | Output of the last replica stage |
| launch_o | output | 1 | Start pulse into the replica delay line |
| freq_word_o | output | 4 | Frequency control word for the delay cells |
| locked_o | output | 1 | Four consecutive matched snapshots seen |
| illegal_o | output | 1 | Sticky flag: snapshot 01 was seen |

## Verification
The main risk in this block is a corrupted frequency word or run count. A snapshot taken on the wrong edge, or a step in the wrong direction, shows on freq_word_o at the first rising edge after the falling-edge capture, which is one reference period at most. A run counter that is off by one makes locked_o rise a period early or late within four periods of the first matched snapshot. A lost sticky bit shows on the very next matched snapshot. The bench closes the loop through a behavioural replica line whose stage delay falls as the word rises. It then forces each snapshot code, drives the word into both rails, and toggles the external select. The bench compares all four outputs against its own period model every period.

// File: rtl/fsync_ctrl.sv
module fsync_ctrl #(
  parameter int WORD_W = 4,
  parameter int LOCK_RUN = 4,
  parameter logic [WORD_W-1:0] RST_WORD = 8
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              ext_sel_i,
  input  logic [WORD_W-1:0] ext_word_i,
  input  logic              tap_prev_i,
  input  logic              tap_last_i,
  output logic              launch_o,
  output logic [WORD_W-1:0] freq_word_o,
  output logic              locked_o,
  output logic              illegal_o
);
  localparam int CNT_W = $clog2(LOCK_RUN + 1);
  localparam logic [WORD_W-1:0] WORD_MAX = '1;
  localparam logic [WORD_W-1:0] WORD_MIN = '0;
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(LOCK_RUN);
  localparam logic [1:0] SNAP_SLOW  = 2'b00;
  localparam logic [1:0] SNAP_FAST  = 2'b11;
  localparam logic [1:0] SNAP_MATCH = 2'b10;

  logic              en_q, armed_q;
  logic [1:0]        snap_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  run_q;
  logic              bad_q;

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
      snap_q  <= SNAP_SLOW;
    end else begin
      en_q    <= 1'b1;
      armed_q <= en_q;
      snap_q  <= {tap_prev_i, tap_last_i};
    end
  end

  assign launch_o = en_q & ref_clk;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RST_WORD;
      run_q  <= '0;
      bad_q  <= 1'b0;
    end else if (ext_sel_i) begin
      run_q <= '0;
    end else if (armed_q) begin
      case (snap_q)
        SNAP_SLOW: begin
          if (word_q != WORD_MAX) word_q <= word_q + 1'b1;
          run_q <= '0;
        end
        SNAP_FAST: begin
          if (word_q != WORD_MIN) word_q <= word_q - 1'b1;
          run_q <= '0;
        end
        SNAP_MATCH: begin
          if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
        end
        default: begin
          run_q <= '0;
          bad_q <= 1'b1;
        end
      endcase
    end
  end

  assign freq_word_o = ext_sel_i ? ext_word_i : word_q;
  assign locked_o    = (run_q == RUN_FULL);
  assign illegal_o   = bad_q;
endmodule

module fsync_ctrl_chk #(
  parameter int WORD_W = 4
) (
  input logic              ref_clk,
  input logic              rst_n,
  input logic              ext_sel_i,
  input logic [WORD_W-1:0] freq_word_o,
  input logic              locked_o,
  input logic              illegal_o
);
  localparam logic [WORD_W-1:0] TOP = '1;

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      // R1
      reset_state_chk: assert (!locked_o && !illegal_o);
    end
  end

  // R10
  one_step_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!ext_sel_i && $past(!ext_sel_i)) |->
      (freq_word_o == $past(freq_word_o) ||
       {1'b0, freq_word_o} == {1'b0, $past(freq_word_o)} + 1'b1 ||
       {1'b0, freq_word_o} + 1'b1 == {1'b0, $past(freq_word_o)}));

  // R6
  no_wrap_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!ext_sel_i && $past(!ext_sel_i) && $past(freq_word_o) == TOP) |-> (freq_word_o != '0));

  // R7
  sticky_flag_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(illegal_o) |-> illegal_o);

  // R9
  ext_unlock_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(ext_sel_i) |-> !locked_o);

  // R8
  lock_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(!ext_sel_i));
endmodule

bind fsync_ctrl fsync_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .ext_sel_i(ext_sel_i),
  .freq_word_o(freq_word_o), .locked_o(locked_o), .illegal_o(illegal_o));

// File: tb/fsync_ctrl_bench.sv
`timescale 1ns/1ps
module fsync_ctrl_bench;
  localparam int REF_PERIOD = 100;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sel = 1'b0;
  logic [3:0] ext_word = 4'd0;
  logic force_en = 1'b0;
  logic [1:0] force_code = 2'b00;
  logic line_prev = 1'b0, line_last = 1'b0;
  logic launch;
  logic [3:0] word;
  logic locked, illegal;
  wire tap_prev = force_en ? force_code[1] : line_prev;
  wire tap_last = force_en ? force_code[0] : line_last;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_word, m_run, m_ill;
  bit m_armed;
  real d_ns;

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  fsync_ctrl u_fsync_ctrl (
    .ref_clk(ref_clk), .rst_n(rst_n), .ext_sel_i(ext_sel), .ext_word_i(ext_word),
    .tap_prev_i(tap_prev), .tap_last_i(tap_last), .launch_o(launch),
    .freq_word_o(word), .locked_o(locked), .illegal_o(illegal));

  // behavioural replica: stage delay (10000 - 350*word) ps, 9 stages
  always @(posedge launch) begin
    #1;
    d_ns = (10000.0 - 350.0 * real'(word)) / 1000.0;
    line_prev <= #(8.0 * d_ns) 1'b1;
    line_last <= #(9.0 * d_ns) 1'b1;
    line_prev <= #79.0 1'b0;
    line_last <= #79.0 1'b0;
  end

  function automatic int auto_code(input int w);
    int d;
    d = 10000 - 350 * w;
    return (((1000 + 8 * d) < 50000) ? 2 : 0) + (((1000 + 9 * d) < 50000) ? 1 : 0);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input string req);
    int ow, code;
    ow = ext_sel ? int'(ext_word) : m_word;
    code = force_en ? int'(force_code) : auto_code(ow);
    if (ext_sel) m_run = 0;
    else if (m_armed) begin
      case (code)
        0: begin if (m_word < 15) m_word++; m_run = 0; end
        3: begin if (m_word > 0) m_word--; m_run = 0; end
        2: begin if (m_run < 4) m_run++; end
        default: begin m_run = 0; m_ill = 1; end
      endcase
    end
    m_armed = 1;
    @(posedge ref_clk); #25;
    chk(req, "freq_word", int'(word), ext_sel ? int'(ext_word) : m_word);
    chk(req, "locked", int'(locked), (m_run == 4) ? 1 : 0);
    chk(req, "illegal", int'(illegal), m_ill);
    chk("R2", "launch high", int'(launch), 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge ref_clk);
    #25;
    chk("R1", "reset word", int'(word), 8);
    chk("R1", "reset locked", int'(locked), 0);
    chk("R1", "reset illegal", int'(illegal), 0);
    chk("R1", "reset launch", int'(launch), 0);
    rst_n = 1'b1;
    m_word = 8; m_run = 0; m_ill = 0; m_armed = 0;
  endtask

  initial begin
    #(REF_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // closed loop from 8: four slow snapshots reach 12, then matched run
    for (int i = 0; i < 12; i++) step("R3");
    chk("R8", "auto lock word", int'(word), 12);
    chk("R8", "auto locked", int'(locked), 1);
    #50;
    chk("R2", "launch low phase", int'(launch), 0);
    #50;
    force_en = 1'b1;
    force_code = 2'b11;
    for (int i = 0; i < 15; i++) step("R4");
    chk("R6", "floor", int'(word), 0);
    force_code = 2'b00;
    for (int i = 0; i < 18; i++) step("R6");
    chk("R6", "ceiling", int'(word), 15);
    force_code = 2'b10;
    for (int i = 0; i < 3; i++) step("R8");
    chk("R8", "not yet locked", int'(locked), 0);
    step("R8");
    chk("R8", "locked on 4th", int'(locked), 1);
    force_code = 2'b01;
    step("R7");
    chk("R5", "01 holds word", int'(word), 15);
    chk("R7", "illegal set", int'(illegal), 1);
    force_code = 2'b10;
    for (int i = 0; i < 2; i++) step("R7");
    force_code = 2'b11;
    step("R8");
    force_code = 2'b10;
    for (int i = 0; i < 5; i++) step("R5");
    ext_word = 4'd3;
    ext_sel = 1'b1;
    force_code = 2'b00;
    for (int i = 0; i < 3; i++) step("R9");
    force_code = 2'b01;
    step("R9");
    force_code = 2'b10;
    ext_sel = 1'b0;
    step("R9");
    chk("R9", "held word back", int'(word), 14);
    force_en = 1'b0;
    for (int i = 0; i < 6; i++) step("R10");
    do_reset();
    force_en = 1'b1;
    force_code = 2'b00;
    step("R3");
    chk("R3", "no update at first edge", int'(word), 8);
    step("R3");
    chk("R3", "first step at second edge", int'(word), 9);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule